// File: doc/BRIEF.md
# Non-volatile byte write sequencer with stop and recovery control

This block holds an 8-bit control register for an on-chip non-volatile byte array and runs the timing of every byte write into it. Software sets a write enable, a two-bit write-time code and a stop bit. It does this either by writing the whole byte or by setting or clearing a single bit. It reads the register back, and the live busy status appears in bit 1. A bus write request carries an address and a data byte. If the request is accepted, the block latches both and holds the array write strobe high for a fixed number of clock cycles. The code picks that number. Each length is a sum of two powers of two.

A state machine centres the design. Its four states are `S_RUN` (operating and idle), `S_WRITE` (write in progress), `S_STOP` (array stopped) and `S_RECOVER` (timed wait after leaving stop). The transitions are:

- start: `S_RUN` to `S_WRITE` when an accepted request arrives.
- finish: `S_WRITE` to `S_RUN` when the duration counter reaches zero.
- abort: `S_WRITE` to `S_RUN` when the enable bit is found clear.
- enter-stop: `S_RUN` to `S_STOP` when the stop bit is set.
- wake: `S_STOP` to `S_RECOVER` when the stop bit is cleared.
- re-stop: `S_RECOVER` to `S_STOP` when the stop bit is set again.
- recovered: `S_RECOVER` to `S_RUN` when the recovery counter reaches zero.

A stop request made during a write waits until that write has ended. Read requests get an immediate grant or not-ready answer.

Top module: `eewr_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `busy`, `arr_stop` and `err_flag` are 0 and `ready` is 1. The readback layout is bit 0 enable, bit 1 busy, bit 2 stop and bits 5:4 write-time code. Bits 3, 6 and 7 always read 0, whatever was written to them.
- R2: A byte write (`reg_wr`) loads enable, stop and code from bits 0, 2 and 5:4 of `reg_wdata`. A single-bit write (`bit_wr`) sets or clears the bit at position `bit_sel` (0, 2, 4 or 5) to `bit_val`. Positions 1, 3, 6 and 7 are left unchanged, so busy cannot be written. A byte write wins over a single-bit write in the same cycle.
- R3: An accepted write raises `busy` and `arr_we` on the clock edge that samples `req_wr`, and presents the latched `arr_addr` and `arr_wdata`. Both strobes stay high for exactly 2^HI_EXP + 2^LO_EXP cycles when the code is 00, and for 2^(HI_EXP+1) + 2^(LO_EXP+1) cycles when it is 01.
- R4: With enable at 0, a write request is ignored in every state. No write starts and no error is raised.
- R5: Clearing enable during a write ends it. `busy` and `arr_we` fall on the clock edge after the one that stores the cleared bit.
- R6: With enable at 1, a write request is rejected and sets the sticky `err_flag` in two cases: the code is 10 or 11, or the state is `S_STOP` or `S_RECOVER`. A rejected request starts no write. Only a cycle with `err_clr` high clears the flag.
- R7: Setting the stop bit while idle moves the block to `S_STOP` on the next edge, with `arr_stop` 1 and `ready` 0. Setting it during a write waits until the write ends, and `arr_stop` stays 0 while `busy` is 1.
- R8: After the stop bit is cleared, `ready` returns to 1 exactly REC+1 clock edges after the edge that stores the cleared bit, where REC = ceil(CLK_HZ * RECOV_US / 10^6).
- R9: A read request (`req_rd`) gets `rd_ok` only in `S_RUN`. In every other state, whether busy, stopped or recovering, it gets `rd_nrdy` in the same cycle.
- R10: The write length is fixed when the write starts. Changing the code during the write does not change it.
- R11: A write request made while `busy` is 1 is ignored. The latched address and data stay as they were, and the running length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Whole-byte register write strobe |
| reg_wdata | input | 8 | Register write data |
| bit_wr | input | 1 | Single-bit set/clear strobe |
| bit_sel | input | 3 | Bit position for single-bit write |
| bit_val | input | 1 | Value for single-bit write |
| reg_rdata | output | 8 | Register readback |
| err_clr | input | 1 | Clears the error flag |
| err_flag | output | 1 | Sticky rejected-request flag |
| req_wr | input | 1 | Byte write request |
| req_addr | input | AW | Write request address |
| req_data | input | 8 | Write request data |
| req_rd | input | 1 | Read request |
| rd_ok | output | 1 | Read granted |
| rd_nrdy | output | 1 | Read refused, not ready |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | AW | Latched write address |
| arr_wdata | output | 8 | Latched write data |
| arr_stop | output | 1 | Array stop control |
| busy | output | 1 | Write in progress |
| ready | output | 1 | Not stopped and not recovering |

## Verification
The bench builds the block with HI_EXP=6 and LO_EXP=2. That gives write lengths of 68 and 136 cycles, so every write, abort and mid-write code change fits in a short run with exact cycle counting. It sets CLK_HZ=1234567 with RECOV_US=20. This gives a recovery of 25 cycles through a fractional product that must round up. Both window lengths can then be checked cycle by cycle.

// File: rtl/eewr_pkg.sv
package eewr_pkg;
    typedef enum logic [1:0] {
        S_RUN     = 2'd0,
        S_WRITE   = 2'd1,
        S_STOP    = 2'd2,
        S_RECOVER = 2'd3
    } eewr_state_e;

    localparam int BIT_WEN  = 0;
    localparam int BIT_BUSY = 1;
    localparam int BIT_STOP = 2;
    localparam int BIT_C0   = 4;
    localparam int BIT_C1   = 5;
endpackage

// File: rtl/eewr_regs.sv
module eewr_regs
    import eewr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       bit_wr,
    input  logic [2:0] bit_sel,
    input  logic       bit_val,
    input  logic       busy,
    output logic       wen,
    output logic       stop,
    output logic [1:0] code,
    output logic [7:0] rdata
);
    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[7:6], reg_wdata[3], reg_wdata[1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wen  <= 1'b0;
            stop <= 1'b0;
            code <= 2'b00;
        end else if (reg_wr) begin
            wen  <= reg_wdata[BIT_WEN];
            stop <= reg_wdata[BIT_STOP];
            code <= reg_wdata[BIT_C1:BIT_C0];
        end else if (bit_wr) begin
            case (bit_sel)
                3'(BIT_WEN):  wen     <= bit_val;
                3'(BIT_STOP): stop    <= bit_val;
                3'(BIT_C0):   code[0] <= bit_val;
                3'(BIT_C1):   code[1] <= bit_val;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata           = 8'h00;
        rdata[BIT_WEN]  = wen;
        rdata[BIT_BUSY] = busy;
        rdata[BIT_STOP] = stop;
        rdata[BIT_C0]   = code[0];
        rdata[BIT_C1]   = code[1];
    end

    AST_BYTE_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (wen == $past(reg_wdata[BIT_WEN])) && (stop == $past(reg_wdata[BIT_STOP]))
                   && (code == $past(reg_wdata[BIT_C1:BIT_C0]))); // R2
endmodule

// File: rtl/eewr_timer.sv
module eewr_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !load && zero |=> zero); // R3
endmodule

// File: rtl/eewr_fsm.sv
module eewr_fsm
    import eewr_pkg::*;
#(
    parameter int AW   = 8,
    parameter int CW   = 16,
    parameter int DUR0 = 17408,
    parameter int REC  = 160
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen,
    input  logic          stop,
    input  logic [1:0]    code,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          err_clr,
    input  logic          tmr_zero,
    output eewr_state_e   state,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic [AW-1:0] arr_addr,
    output logic [7:0]    arr_wdata,
    output logic          err
);
    localparam int DUR1 = 2 * DUR0;

    eewr_state_e state_nx;
    logic        accept;
    logic        reject;

    assign accept = (state == S_RUN) && req_wr && wen && !code[1] && !stop;
    assign reject = req_wr && wen &&
                    (((state == S_RUN) && (code[1] || stop)) ||
                     (state == S_STOP) || (state == S_RECOVER));

    always_comb begin
        state_nx = state;
        unique case (state)
            S_RUN:     if (accept)        state_nx = S_WRITE;
                       else if (stop)     state_nx = S_STOP;
            S_WRITE:   if (!wen)          state_nx = S_RUN;
                       else if (tmr_zero) state_nx = S_RUN;
            S_STOP:    if (!stop)         state_nx = S_RECOVER;
            S_RECOVER: if (stop)          state_nx = S_STOP;
                       else if (tmr_zero) state_nx = S_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = CW'(REC - 1);
        unique case (state)
            S_RUN: if (accept) begin
                tmr_load = 1'b1;
                tmr_val  = code[0] ? CW'(DUR1 - 1) : CW'(DUR0 - 1);
            end
            S_STOP:    tmr_load = !stop;
            S_WRITE:   tmr_load = 1'b0;
            S_RECOVER: tmr_load = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_addr  <= '0;
            arr_wdata <= '0;
            err       <= 1'b0;
        end else begin
            if (accept) begin
                arr_addr  <= req_addr;
                arr_wdata <= req_data;
            end
            if (reject)       err <= 1'b1;
            else if (err_clr) err <= 1'b0;
        end
    end

    AST_NO_START_WITHOUT_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN) && req_wr && !wen |=> state != S_WRITE); // R4
    AST_ABORT_ON_WEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE) && !wen |=> state == S_RUN); // R5
    AST_WRITE_ENDS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE) && wen && tmr_zero |=> state == S_RUN); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err && !err_clr |=> err); // R6
    AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP) && stop |=> state == S_STOP); // R7
    AST_WRITE_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRITE) && $past(state == S_WRITE) |-> $stable(arr_addr) && $stable(arr_wdata)); // R11
endmodule

// File: rtl/eewr_ctrl.sv
module eewr_ctrl
    import eewr_pkg::*;
#(
    parameter int AW       = 8,
    parameter int HI_EXP   = 14,
    parameter int LO_EXP   = 10,
    parameter int CLK_HZ   = 8_000_000,
    parameter int RECOV_US = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    input  logic          bit_wr,
    input  logic [2:0]    bit_sel,
    input  logic          bit_val,
    output logic [7:0]    reg_rdata,
    input  logic          err_clr,
    output logic          err_flag,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          req_rd,
    output logic          rd_ok,
    output logic          rd_nrdy,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [7:0]    arr_wdata,
    output logic          arr_stop,
    output logic          busy,
    output logic          ready
);
    localparam int     DUR0  = (1 << HI_EXP) + (1 << LO_EXP);
    localparam int     DUR1  = 2 * DUR0;
    localparam longint REC_L = (longint'(CLK_HZ) * RECOV_US + 999_999) / 1_000_000;
    localparam int     REC   = (REC_L < 1) ? 1 : int'(REC_L);
    localparam int     CMAX  = (DUR1 > REC) ? DUR1 : REC;
    localparam int     CW    = $clog2(CMAX + 1);

    logic          wen, stop, tmr_load, tmr_zero;
    logic [1:0]    code;
    logic [CW-1:0] tmr_val;
    eewr_state_e   state;

    eewr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .bit_wr(bit_wr), .bit_sel(bit_sel), .bit_val(bit_val), .busy(busy),
        .wen(wen), .stop(stop), .code(code), .rdata(reg_rdata)
    );

    eewr_fsm #(.AW(AW), .CW(CW), .DUR0(DUR0), .REC(REC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wen(wen), .stop(stop), .code(code),
        .req_wr(req_wr), .req_addr(req_addr), .req_data(req_data),
        .err_clr(err_clr), .tmr_zero(tmr_zero), .state(state),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .err(err_flag)
    );

    eewr_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    assign busy     = (state == S_WRITE);
    assign arr_we   = busy;
    assign arr_stop = (state == S_STOP);
    assign ready    = (state == S_RUN) || (state == S_WRITE);
    assign rd_ok    = req_rd && (state == S_RUN);
    assign rd_nrdy  = req_rd && !rd_ok;

    AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rd_ok); // R9
    AST_STOP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_stop |-> !ready && !busy); // R7
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr) |-> (reg_rdata[7:6] == 2'b00) && !reg_rdata[3]); // R1
endmodule

// File: tb/test_eewr_ctrl.sv
`timescale 1ns/1ps
module test_eewr_ctrl;
    localparam int AW     = 8;
    localparam int HI     = 6;
    localparam int LO     = 2;
    localparam int CLKHZ  = 1_234_567;
    localparam int REC_US = 20;
    localparam int REC_X  = (CLKHZ * REC_US + 999_999) / 1_000_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 0, bit_wr = 0, bit_val = 0, err_clr = 0, req_wr = 0, req_rd = 0;
    logic [7:0] reg_wdata = 0, req_data = 0;
    logic [2:0] bit_sel = 0;
    logic [AW-1:0] req_addr = 0;
    logic [7:0] reg_rdata, arr_wdata;
    logic [AW-1:0] arr_addr;
    logic err_flag, rd_ok, rd_nrdy, arr_we, arr_stop, busy, ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    eewr_ctrl #(.AW(AW), .HI_EXP(HI), .LO_EXP(LO), .CLK_HZ(CLKHZ), .RECOV_US(REC_US)) i_eewr_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .bit_wr(bit_wr),
        .bit_sel(bit_sel), .bit_val(bit_val), .reg_rdata(reg_rdata), .err_clr(err_clr),
        .err_flag(err_flag), .req_wr(req_wr), .req_addr(req_addr), .req_data(req_data),
        .req_rd(req_rd), .rd_ok(rd_ok), .rd_nrdy(rd_nrdy), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_stop(arr_stop), .busy(busy), .ready(ready)
    );

    function automatic int f_dur(input logic c0);
        int d = (1 << HI) + (1 << LO);
        return c0 ? 2 * d : d;
    endfunction

    function automatic logic [7:0] f_rd(input logic [7:0] m, input logic b);
        return {2'b00, m[5:4], 1'b0, m[2], b, m[0]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic byte_wr(input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic bit_op(input logic [2:0] s, input logic v);
        @(negedge clk); bit_wr = 1; bit_sel = s; bit_val = v;
        @(negedge clk); bit_wr = 0;
    endtask

    task automatic start_wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); req_wr = 1; req_addr = a; req_data = d;
        @(negedge clk); req_wr = 0;
    endtask

    task automatic clr_err();
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] m;
        int cnt;
        logic [AW-1:0] seen_a;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset rdata", reg_rdata, 0);
        check("R1 reset busy", busy, 0);
        check("R1 reset ready", ready, 1);
        check("R1 reset stop/err", {arr_stop, err_flag}, 0);

        // R1 reserved bits read 0
        byte_wr(8'hFF);
        check("R1 reserved bits", reg_rdata, 8'h35);
        byte_wr(8'h00);
        wait_ready();

        // R2 random byte and bit writes, stop bit kept 0
        m = 8'h00;
        for (int i = 0; i < 40; i++) begin
            if ($urandom_range(1, 0) == 1) begin
                logic [7:0] d = 8'($urandom) & 8'hFB;
                byte_wr(d);
                m = d;
            end else begin
                logic [2:0] s = 3'($urandom_range(7, 0));
                logic v = 1'($urandom);
                if (s == 3'd2) s = 3'd1;
                bit_op(s, v);
                if (s == 3'd0 || s == 3'd4 || s == 3'd5) m[s] = v;
            end
            check("R2 readback", reg_rdata, f_rd(m, 1'b0));
        end
        bit_op(3'd1, 1'b1);
        check("R2 busy not writable", reg_rdata[1], 0);

        // R9 read granted when idle
        @(negedge clk); req_rd = 1; #1;
        check("R9 read ok idle", {rd_ok, rd_nrdy}, 2'b10);
        req_rd = 0;

        // R4 write ignored with enable 0
        byte_wr(8'h10);
        start_wr(8'h12, 8'h34);
        check("R4 no start", {busy, arr_we, err_flag}, 0);

        // R3 random writes with measured length
        for (int i = 0; i < 4; i++) begin
            logic c0 = 1'($urandom);
            logic [AW-1:0] a = AW'($urandom);
            logic [7:0] d = 8'($urandom);
            byte_wr({2'b00, 1'b0, c0, 4'b0001});
            start_wr(a, d);
            check("R3 addr", arr_addr, a);
            check("R3 data", arr_wdata, d);
            cnt = 0;
            while (busy) begin
                cnt++;
                if (cnt == 3) begin req_rd = 1; #1; check("R9 refused busy", {rd_ok, rd_nrdy}, 2'b01); req_rd = 0; end
                @(negedge clk);
            end
            check("R3 length", cnt, f_dur(c0));
        end

        // R10 + R11: code change and extra request during write
        byte_wr(8'h01);
        start_wr(8'hA5, 8'h5A);
        cnt = 0;
        seen_a = '0;
        while (busy) begin
            cnt++;
            reg_wr = (cnt == 5);
            reg_wdata = 8'h11;
            req_wr = (cnt == 10);
            req_addr = 8'h3C;
            if (cnt == 30) seen_a = arr_addr;
            @(negedge clk);
        end
        reg_wr = 0; req_wr = 0;
        check("R10 length latched", cnt, f_dur(1'b0));
        check("R11 addr kept", seen_a, 8'hA5);
        check("R11 no error", err_flag, 0);

        // R5 abort
        byte_wr(8'h01);
        start_wr(8'h01, 8'h02);
        repeat (10) @(negedge clk);
        bit_op(3'd0, 1'b0);
        @(negedge clk);
        check("R5 aborted", {busy, arr_we}, 0);

        // R6 prohibited code
        byte_wr(8'h21);
        start_wr(8'h01, 8'h02);
        check("R6 code10 no start", busy, 0);
        check("R6 code10 error", err_flag, 1);
        repeat (3) @(negedge clk);
        check("R6 sticky", err_flag, 1);
        clr_err();
        check("R6 cleared", err_flag, 0);

        // R7 stop from idle
        byte_wr(8'h05);
        @(negedge clk);
        check("R7 stop entered", {arr_stop, ready}, 2'b10);
        @(negedge clk); req_rd = 1; #1;
        check("R9 refused stop", {rd_ok, rd_nrdy}, 2'b01);
        req_rd = 0;
        start_wr(8'h07, 8'h08);
        check("R6 stop reject", {busy, err_flag}, 2'b01);
        clr_err();

        // R8 recovery length
        bit_op(3'd2, 1'b0);
        cnt = 0;
        while (!ready) begin
            cnt++;
            req_wr = (cnt == 5);
            if (cnt == 3) begin req_rd = 1; #1; check("R9 refused recovering", {rd_ok, rd_nrdy}, 2'b01); end
            else req_rd = 0;
            @(negedge clk);
        end
        req_wr = 0; req_rd = 0;
        check("R8 recovery length", cnt, REC_X + 1);
        check("R6 recovery reject", {busy, err_flag}, 2'b01);
        clr_err();

        // R7 stop during write waits
        byte_wr(8'h01);
        start_wr(8'h09, 8'h0A);
        repeat (5) @(negedge clk);
        bit_op(3'd2, 1'b1);
        check("R7 pending", {busy, arr_stop}, 2'b10);
        while (busy) @(negedge clk);
        @(negedge clk);
        check("R7 stop after write", {arr_stop, ready}, 2'b10);
        bit_op(3'd2, 1'b0);
        wait_ready();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule